// File: doc/BRIEF.md
# PLL Clock Control Register with Interlocks

This block is an 8-bit clock control register with a simple write port and a continuous read-back. Its fields drive the PLL enable, a 2-bit multiplication ratio, the system clock source select, and two peripheral clock select bits. Software writes a byte. The block then applies cross-field rules before it stores each field. Because of these rules, the system clock can only move to the PLL output once the PLL is enabled, has a legal ratio, and has had time to settle.

The ratio accepts a single change after reset, and that change is accepted only when the same write leaves the clock select at 0. Enabling the PLL or changing the ratio loads a settle down-counter. A `settling` flag shows that the counter is running, and requests to select the PLL clock are ignored until it reaches zero. Clearing the enable pulls the clock select back to the crystal clock in the same write. A stop input forces the PLL-active output low whatever the enable holds.

Top module: `pll_clkctl`

## Requirements
- R1: While reset is held, and directly after it, `rd_data` reads 0x1B: enable=1, ratio=2'b10 (x3), select=0, peripheral bits=00. The settle counter starts loaded, so `settling` is 1 and stays 1 for exactly SETTLE_CYCLES clock edges after reset is released.
- R2: Read-back bits 0 and 4 are always 1, whatever is written. `rd_data` layout: [7:6] peripheral select, [5] clock select, [4] 1, [3:2] ratio, [1] enable, [0] 1.
- R3: A write with bit 1 = 0 stores enable=0 and clears the clock select to 0 in the same cycle.
- R4: While the stored enable is 0, a write with bit 5 = 1 leaves the clock select at 0. This includes the write that sets the enable from 0 to 1.
- R5: A write changes the ratio only when all of the following hold: no ratio change has been accepted since reset, the written bits 3:2 differ from the stored ratio, and write bit 5 = 0. An accepted change sets the sticky `ratio_locked` output, which only reset clears.
- R6: Once `ratio_locked` is 1, writes never alter the ratio.
- R7: A written ratio of 2'b00 is never stored. The stored ratio is always 01 (x2), 10 (x3) or 11 (x4).
- R8: An accepted ratio change, or a write that sets the enable from 0 to 1, reloads the settle counter to SETTLE_CYCLES. `settling` is then 1 for exactly that many edges. A write with bit 5 = 1 is ignored while `settling` is 1.
- R9: A write with bits 5 and 1 set, with the stored enable at 1 and `settling` at 0, sets the clock select to 1. Any write with bit 5 = 0 clears it.
- R10: `pll_active` is 1 only when the stored enable is 1 and `stop_mode` is 0.
- R11: The peripheral select bits take write bits 7:6 unconditionally. `pll_en`, `pll_ratio`, `sysclk_sel` and `periph_sel` mirror the stored fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_data | input | 8 | Byte to write |
| stop_mode | input | 1 | Stop mode; forces the PLL inactive |
| rd_data | output | 8 | Register read-back |
| pll_en | output | 1 | PLL enable |
| pll_ratio | output | 2 | Multiplication ratio code |
| sysclk_sel | output | 1 | 0 = crystal clock, 1 = PLL clock |
| periph_sel | output | 2 | Peripheral clock select |
| pll_active | output | 1 | PLL effectively running |
| settling | output | 1 | Settle counter nonzero |
| ratio_locked | output | 1 | Single ratio change used |

## Verification
Several rules can fall on the same write. A single byte can clear the enable while asking for the PLL clock. It can also request a ratio change and the PLL clock together, or set the enable from 0 to 1 with the select bit raised. A clock-select request can also arrive on the very edge at which the settle counter reaches zero. The bench provokes these cases by writing every one of the 256 byte values from a freshly reset, settled state. It then runs scripted and pseudo-random write streams with writes timed against the counter. Each outcome is judged against a field-by-field model built from the requirements.

// File: rtl/pll_clkctl.sv
module pll_clkctl #(
  parameter int SETTLE_CYCLES = 32000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       stop_mode,
  output logic [7:0] rd_data,
  output logic       pll_en,
  output logic [1:0] pll_ratio,
  output logic       sysclk_sel,
  output logic [1:0] periph_sel,
  output logic       pll_active,
  output logic       settling,
  output logic       ratio_locked
);
  localparam int CW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(SETTLE_CYCLES);

  logic [CW-1:0] cnt;
  logic          en_q, sel_q, lock_q;
  logic [1:0]    ratio_q, per_q;

  wire       w_en    = wr_data[1];
  wire       w_sel   = wr_data[5];
  wire [1:0] w_ratio = wr_data[3:2];

  wire ratio_take = wr_en && !lock_q && (w_ratio != 2'b00) &&
                    (w_ratio != ratio_q) && !w_sel;
  wire en_rise    = wr_en && w_en && !en_q;
  wire sel_take   = w_sel && w_en && en_q && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b1;
      ratio_q <= 2'b10;
      sel_q   <= 1'b0;
      per_q   <= 2'b00;
      lock_q  <= 1'b0;
    end else if (wr_en) begin
      en_q  <= w_en;
      per_q <= wr_data[7:6];
      sel_q <= sel_take;
      if (ratio_take) begin
        ratio_q <= w_ratio;
        lock_q  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt <= LOAD;
    else if (ratio_take || en_rise) cnt <= LOAD;
    else if (cnt != '0)             cnt <= cnt - 1'b1;
  end

  assign rd_data      = {per_q, sel_q, 1'b1, ratio_q, en_q, 1'b1};
  assign pll_en       = en_q;
  assign pll_ratio    = ratio_q;
  assign sysclk_sel   = sel_q;
  assign periph_sel   = per_q;
  assign pll_active   = en_q && !stop_mode;
  assign settling     = (cnt != '0);
  assign ratio_locked = lock_q;
endmodule

module pll_clkctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pll_en,
  input logic [1:0] pll_ratio,
  input logic       sysclk_sel,
  input logic       settling,
  input logic       ratio_locked
);
  AST_SEL_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    sysclk_sel |-> pll_en);                                   // R4
  AST_CLEAR_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_en) |-> !sysclk_sel);                           // R3
  AST_SEL_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sysclk_sel) |-> $past(!settling));                  // R8
  AST_ENABLE_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_en) |-> settling);                              // R8
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_locked |=> ratio_locked);                           // R5
  AST_RATIO_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_locked |=> $stable(pll_ratio));                     // R6
  AST_RATIO_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    pll_ratio != 2'b00);                                      // R7
endmodule

bind pll_clkctl pll_clkctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pll_en(pll_en), .pll_ratio(pll_ratio),
  .sysclk_sel(sysclk_sel), .settling(settling), .ratio_locked(ratio_locked)
);

// File: tb/pll_clkctl_tb.sv
`timescale 1ns/1ps
module pll_clkctl_tb;
  localparam int N = 8;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, stop_mode = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic pll_en, sysclk_sel, pll_active, settling, ratio_locked;
  logic [1:0] pll_ratio, periph_sel;

  int checks = 0, errors = 0;
  bit done = 0;

  bit m_en, m_sel, m_lock;
  logic [1:0] m_ratio, m_per;
  int m_cnt;

  always #4 clk = ~clk;

  pll_clkctl #(.SETTLE_CYCLES(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .stop_mode(stop_mode), .rd_data(rd_data), .pll_en(pll_en),
    .pll_ratio(pll_ratio), .sysclk_sel(sysclk_sel), .periph_sel(periph_sel),
    .pll_active(pll_active), .settling(settling), .ratio_locked(ratio_locked));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R2/R11 rd_data", rd_data, {m_per, m_sel, 1'b1, m_ratio, m_en, 1'b1});
    chk("R3/R4/R9 sysclk_sel", sysclk_sel, m_sel);
    chk("R5/R6/R7 pll_ratio", pll_ratio, m_ratio);
    chk("R5 ratio_locked", ratio_locked, m_lock);
    chk("R8 settling", settling, m_cnt != 0);
    chk("R10 pll_active", pll_active, m_en && !stop_mode);
    chk("R11 pll_en", pll_en, m_en);
    chk("R11 periph_sel", periph_sel, m_per);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0;
    m_en = 1; m_sel = 0; m_lock = 0; m_ratio = 2'b10; m_per = 2'b00; m_cnt = N;
    @(negedge clk);
    chk("R1 reset rd_data", rd_data, 8'h1B);
    chk("R1 reset settling", settling, 1);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one clock: inputs applied at the negedge, outputs compared at the next negedge
  task automatic cyc(input bit we, input logic [7:0] v, input bit stp);
    bit rok, rise, snew;
    wr_en = we; wr_data = v; stop_mode = stp;
    @(posedge clk);
    if (we) begin
      rok  = !m_lock && v[3:2] != 2'b00 && v[3:2] != m_ratio && !v[5];
      rise = v[1] && !m_en;
      snew = v[5] && v[1] && m_en && m_cnt == 0;
      if (rok) begin m_ratio = v[3:2]; m_lock = 1; end
      m_en = v[1]; m_per = v[7:6]; m_sel = snew;
      if (rok || rise) m_cnt = N;
      else if (m_cnt > 0) m_cnt--;
    end else if (m_cnt > 0) m_cnt--;
    @(negedge clk);
    wr_en = 1'b0;
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 8'h00, 0);
  endtask

  initial begin
    logic [15:0] lfsr;
    @(negedge clk);
    do_reset();
    // R1: settling high for exactly N edges after release
    idle(N - 1);
    chk("R1 settling before expiry", settling, 1);
    idle(1);
    chk("R1 settling expired", settling, 0);

    // scripted interactions
    do_reset();
    cyc(1, 8'h3B, 0);            // R8 select while settling ignored
    chk("R8 select blocked", sysclk_sel, 0);
    idle(N);
    cyc(1, 8'h3B, 0);            // R9 select accepted
    chk("R9 select set", sysclk_sel, 1);
    cyc(1, 8'h37, 0);            // R5 ratio with select=1 rejected
    chk("R5 ratio rejected with select", pll_ratio, 2'b10);
    cyc(1, 8'h13, 0);            // R7 ratio 00 ignored
    chk("R7 ratio 00 ignored", pll_ratio, 2'b10);
    cyc(1, 8'h17, 1);            // R5 ratio accepted, R10 stop
    chk("R5 ratio accepted", pll_ratio, 2'b01);
    chk("R10 stop forces inactive", pll_active, 0);
    cyc(1, 8'h1F, 0);            // R6 locked
    chk("R6 ratio locked", pll_ratio, 2'b01);
    idle(N);
    cyc(1, 8'hF7, 0);
    chk("R9 select with x2", sysclk_sel, 1);
    cyc(1, 8'h31, 0);            // R3 disable with select requested
    chk("R3 select cleared", sysclk_sel, 0);
    idle(N + 2);
    cyc(1, 8'h33, 0);            // R4 enable rise with select
    chk("R4 select blocked on enable rise", sysclk_sel, 0);
    chk("R8 reload on enable", settling, 1);
    idle(N - 1);
    cyc(1, 8'h37, 0);            // select on the expiry edge
    chk("R8 select on last settle edge", sysclk_sel, 0);
    cyc(1, 8'h37, 0);
    chk("R9 select after expiry", sysclk_sel, 1);

    // exhaustive: every byte from a fresh settled state
    for (int v = 0; v < 256; v++) begin
      do_reset();
      idle(N);
      cyc(1, v[7:0], v[0]);
      cyc(1, 8'h3B, 0);
      idle(1);
    end

    // pseudo-random streams with occasional resets
    lfsr = 16'hACE1;
    for (int i = 0; i < 6000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[15:10] == 6'h3F) do_reset();
      else cyc(lfsr[0] | lfsr[1], {lfsr[9:4], lfsr[3], 1'b1} ^ {lfsr[2], 7'h0},
               lfsr[11] & lfsr[12]);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule